// File: doc/BRIEF.md
# Ring Rotation Reorder Buffer for Time-Shared Routers

A single physical router can stand in for N virtual routers by stepping through them in a fixed order, one instance per step. In that setup, a message leaving instance x on a ring link has to be handed to a neighbouring instance on the input side. The outgoing stream is produced in instance order 0..N-1 and the incoming stream is consumed in that same order. This block reorders a group of N messages by a fixed rotation so that each message lands in the slot of its destination. It uses a small side store and does not need a general indirection table.

A parameter selects the direction. In the forward variant the first message of each group is set aside and emitted last, so output slot p carries input (p+1) mod N. In the backward variant, which serves the opposite ring direction, the last message of a group goes out first, so output slot p carries input (p+N-1) mod N. The backward variant has to collect N-1 messages before it can emit anything. Slots with no real link still occupy their step and carry an empty marker. Both sides use a valid/ready handshake, and every output is tagged with the index of its destination slot.

Top module: `ring_rot_buffer`

## Requirements
- R1: With the forward variant (DIR = ROT_FORWARD), the outputs of each group of N inputs are inputs 1, 2, ..., N-1 followed by input 0.
- R2: With the backward variant (DIR = ROT_BACKWARD), the outputs of each group are input N-1 followed by inputs 0, 1, ..., N-2.
- R3: `out_dst` is the destination slot of the presented message. It is 0 for the first output after reset and rises by one with each accepted output, wrapping from N-1 to 0.
- R4: An input with `in_msg` = 0 is an empty slot. It still takes one input step and one output step, and it appears at its rotated position with `out_msg` = 0 and `out_data` = 0, whatever data came with it.
- R5: In the backward variant, the first N-1 inputs of a group are accepted (`in_ready` = 1) with `out_valid` = 0. The Nth input passes straight to output slot 0. After that, the N-1 stored entries drain on consecutive steps with `in_ready` = 0. With no stalls a group takes 2N-1 steps.
- R6: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0 and the output fields hold their values, so no message is lost or reordered under backpressure.
- R7: In the forward variant, the first input of a group is accepted with no output. The held message is emitted in the same step that captures the first input of the next group. With no stalls, a stream of G groups takes G*N+1 steps.
- R8: After reset, `out_valid` is 0, `in_ready` is 1, and both variants start at group position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input step offered |
| in_ready | output | 1 | Input step accepted this cycle when valid |
| in_msg | input | 1 | 1 = real message, 0 = empty slot |
| in_data | input | DATA_W | Message payload |
| out_valid | output | 1 | Output step offered |
| out_ready | input | 1 | Downstream takes the output step |
| out_msg | output | 1 | 1 = real message, 0 = empty slot |
| out_data | output | DATA_W | Payload, zero for an empty slot |
| out_dst | output | $clog2(N_INST) | Destination slot index of the output |

## Verification
The checker assumes that the source keeps `in_valid` and its payload steady until the step is accepted. It also assumes that inputs arrive as whole groups in instance order, because output stability in the pass-through steps depends on the input holding. The bench always offers the next table entry and advances only after a handshake. It drives inputs at the falling edge, waits a short delay and then samples, and it withdraws `in_valid` only once the stream is exhausted, on a group boundary. Stall patterns toggle `out_ready` only, and each run drains completely before the next run starts.

// File: rtl/ring_rot_pkg.sv
package ring_rot_pkg;
   // Direction of the fixed rotation applied to each group of N steps.
   typedef enum logic {
      ROT_FORWARD  = 1'b0,
      ROT_BACKWARD = 1'b1
   } rot_dir_e;
endpackage

// File: rtl/ring_step_counter.sv
module ring_step_counter #(
   parameter int N_INST = 4,
   localparam int PW = $clog2(N_INST)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   output logic [PW-1:0] pos,
   output logic          last
);
   assign last = (pos == PW'(N_INST - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)   pos <= '0;
      else if (adv) pos <= last ? '0 : pos + 1'b1;
   end
endmodule

// File: rtl/ring_fwd_path.sv
// Forward rotation: the first step of a group waits in a one-entry side
// store and leaves as the last output of the group.
module ring_fwd_path #(
   parameter int N_INST = 4,
   parameter int DATA_W = 8,
   localparam int PW = $clog2(N_INST)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              in_msg,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic              out_msg,
   output logic [DATA_W-1:0] out_data,
   output logic [PW-1:0]     out_dst
);
   logic [PW-1:0]     pos;
   logic              pos_last;
   logic              side_full_q;
   logic              side_msg_q;
   logic [DATA_W-1:0] side_data_q;
   logic [DATA_W-1:0] clean_data;
   logic              in_fire, out_fire;

   assign clean_data = in_msg ? in_data : '0;
   assign in_fire    = in_valid & in_ready;
   assign out_fire   = out_valid & out_ready;

   ring_step_counter #(.N_INST(N_INST)) u_pos (
      .clk(clk), .rst_n(rst_n), .adv(in_fire), .pos(pos), .last(pos_last)
   );

   always_comb begin
      out_valid = 1'b0;
      out_msg   = 1'b0;
      out_data  = '0;
      out_dst   = PW'(N_INST - 1);
      in_ready  = 1'b0;
      if (pos == '0) begin
         if (!side_full_q) begin
            in_ready = 1'b1;
         end else begin
            out_valid = 1'b1;
            out_msg   = side_msg_q;
            out_data  = side_data_q;
            in_ready  = out_ready;
         end
      end else begin
         out_valid = in_valid;
         out_msg   = in_msg;
         out_data  = clean_data;
         out_dst   = pos - 1'b1;
         in_ready  = out_ready;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         side_full_q <= 1'b0;
         side_msg_q  <= 1'b0;
         side_data_q <= '0;
      end else if (pos == '0) begin
         if (in_fire) begin
            side_full_q <= 1'b1;
            side_msg_q  <= in_msg;
            side_data_q <= clean_data;
         end else if (out_fire) begin
            side_full_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/ring_rev_path.sv
// Backward rotation: the first N-1 steps are stored, the last step passes
// straight to slot 0, then the stored steps drain into slots 1..N-1.
module ring_rev_path #(
   parameter int N_INST = 4,
   parameter int DATA_W = 8,
   localparam int PW    = $clog2(N_INST),
   localparam int DEPTH = N_INST - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              in_msg,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic              out_msg,
   output logic [DATA_W-1:0] out_data,
   output logic [PW-1:0]     out_dst
);
   logic [PW-1:0]     cnt, opos;
   logic              cnt_last, opos_last;
   logic              drain_q;
   logic              st_msg_q  [DEPTH];
   logic [DATA_W-1:0] st_data_q [DEPTH];
   logic [DATA_W-1:0] clean_data;
   logic [PW-1:0]     rd_idx;
   logic              in_fire, out_fire;

   assign clean_data = in_msg ? in_data : '0;
   assign in_fire    = in_valid & in_ready;
   assign out_fire   = out_valid & out_ready;
   assign rd_idx     = opos - 1'b1;

   ring_step_counter #(.N_INST(N_INST)) u_in_pos (
      .clk(clk), .rst_n(rst_n), .adv(in_fire), .pos(cnt), .last(cnt_last)
   );

   ring_step_counter #(.N_INST(N_INST)) u_out_pos (
      .clk(clk), .rst_n(rst_n), .adv(out_fire), .pos(opos), .last(opos_last)
   );

   always_comb begin
      out_dst = opos;
      if (drain_q) begin
         out_valid = 1'b1;
         out_msg   = st_msg_q[rd_idx];
         out_data  = st_data_q[rd_idx];
         in_ready  = 1'b0;
      end else if (cnt_last) begin
         out_valid = in_valid;
         out_msg   = in_msg;
         out_data  = clean_data;
         in_ready  = out_ready;
      end else begin
         out_valid = 1'b0;
         out_msg   = 1'b0;
         out_data  = '0;
         in_ready  = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                     drain_q <= 1'b0;
      else if (in_fire && cnt_last)   drain_q <= 1'b1;
      else if (out_fire && opos_last) drain_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (in_fire && !cnt_last) begin
         st_msg_q[cnt]  <= in_msg;
         st_data_q[cnt] <= clean_data;
      end
   end
endmodule

// File: rtl/ring_rot_buffer.sv
module ring_rot_buffer
   import ring_rot_pkg::*;
#(
   parameter int       N_INST = 4,
   parameter int       DATA_W = 8,
   parameter rot_dir_e DIR    = ROT_FORWARD,
   localparam int      DST_W  = $clog2(N_INST)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              in_msg,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic              out_msg,
   output logic [DATA_W-1:0] out_data,
   output logic [DST_W-1:0]  out_dst
);
   if (N_INST < 2) begin : g_bad_inst
      $error("ring_rot_buffer: N_INST must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("ring_rot_buffer: DATA_W must be at least 1");
   end

   if (DIR == ROT_FORWARD) begin : g_fwd
      ring_fwd_path #(.N_INST(N_INST), .DATA_W(DATA_W)) u_path (
         .clk(clk), .rst_n(rst_n),
         .in_valid(in_valid), .in_ready(in_ready),
         .in_msg(in_msg), .in_data(in_data),
         .out_valid(out_valid), .out_ready(out_ready),
         .out_msg(out_msg), .out_data(out_data), .out_dst(out_dst)
      );
   end else begin : g_rev
      ring_rev_path #(.N_INST(N_INST), .DATA_W(DATA_W)) u_path (
         .clk(clk), .rst_n(rst_n),
         .in_valid(in_valid), .in_ready(in_ready),
         .in_msg(in_msg), .in_data(in_data),
         .out_valid(out_valid), .out_ready(out_ready),
         .out_msg(out_msg), .out_data(out_data), .out_dst(out_dst)
      );
   end
endmodule

// File: rtl/ring_rot_checker.sv
module ring_rot_checker
   import ring_rot_pkg::*;
#(
   parameter int       N_INST = 4,
   parameter int       DATA_W = 8,
   parameter rot_dir_e DIR    = ROT_FORWARD,
   localparam int      DST_W  = $clog2(N_INST)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic              in_msg,
   input logic [DATA_W-1:0] in_data,
   input logic              out_valid,
   input logic              out_ready,
   input logic              out_msg,
   input logic [DATA_W-1:0] out_data,
   input logic [DST_W-1:0]  out_dst
);
   localparam int MAX_HELD = (DIR == ROT_FORWARD) ? 1 : N_INST - 1;

   logic [DST_W-1:0] exp_dst_q;
   logic [DST_W:0]   held_q;
   logic             in_fire, out_fire;
   logic             seen_q;

   assign in_fire  = in_valid & in_ready;
   assign out_fire = out_valid & out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exp_dst_q <= '0;
         held_q    <= '0;
         seen_q    <= 1'b0;
      end else begin
         seen_q <= 1'b1;
         if (out_fire)
            exp_dst_q <= (exp_dst_q == DST_W'(N_INST - 1)) ? '0 : exp_dst_q + 1'b1;
         held_q <= held_q + {{DST_W{1'b0}}, in_fire} - {{DST_W{1'b0}}, out_fire};
      end
   end

   // R3: destination tags follow the output order and wrap at N-1
   a_r3_dst_order : assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_dst == exp_dst_q);

   // R4: an empty slot carries zero data
   a_r4_empty_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_msg) |-> out_data == '0);

   // R6: a stalled output blocks the input side
   a_r6_no_take_stalled : assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

   // R6: a stalled output keeps its fields
   a_r6_hold_output : assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && out_valid && !out_ready) |=>
         (out_valid && $stable(out_dst) && $stable(out_msg) && $stable(out_data)));

   // R5 / R7: storage never holds more than the variant allows
   a_r5_occupancy : assert property (@(posedge clk) disable iff (!rst_n)
      int'(held_q) <= MAX_HELD);

   // R8: nothing is offered in the first cycle after reset
   a_r8_reset_idle : assert property (@(posedge clk) disable iff (!rst_n)
      !seen_q |-> (!out_valid && in_ready));
endmodule

bind ring_rot_buffer ring_rot_checker #(
   .N_INST(N_INST), .DATA_W(DATA_W), .DIR(DIR)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .in_valid(in_valid), .in_ready(in_ready),
   .in_msg(in_msg), .in_data(in_data),
   .out_valid(out_valid), .out_ready(out_ready),
   .out_msg(out_msg), .out_data(out_data), .out_dst(out_dst)
);

// File: tb/ring_rot_buffer_tb.sv
`timescale 1ns/1ps
module ring_rot_buffer_tb;
   import ring_rot_pkg::*;

   localparam int N    = 4;
   localparam int DW   = 8;
   localparam int LEN  = 16;
   localparam int GRPS = LEN / N;
   localparam int DSTW = $clog2(N);

   // Stimulus vectors: bit 8 is the message flag, bits 7:0 the payload.
   localparam logic [8:0] VEC [LEN] = '{
      9'h111, 9'h122, 9'h033, 9'h144,
      9'h155, 9'h166, 9'h177, 9'h188,
      9'h199, 9'h0AA, 9'h1BB, 9'h1CC,
      9'h1DD, 9'h1EE, 9'h1F0, 9'h00F
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_msg = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          out_ready = 1'b1;
   logic          sel_rev = 1'b0;

   logic            f_in_ready, f_out_valid, f_out_msg;
   logic [DW-1:0]   f_out_data;
   logic [DSTW-1:0] f_out_dst;
   logic            r_in_ready, r_out_valid, r_out_msg;
   logic [DW-1:0]   r_out_data;
   logic [DSTW-1:0] r_out_dst;

   logic            rd_in_ready, rd_out_valid, rd_out_msg;
   logic [DW-1:0]   rd_out_data;
   logic [DSTW-1:0] rd_out_dst;

   int n_chk  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   ring_rot_buffer #(.N_INST(N), .DATA_W(DW), .DIR(ROT_FORWARD)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid && !sel_rev), .in_ready(f_in_ready),
      .in_msg(in_msg), .in_data(in_data),
      .out_valid(f_out_valid), .out_ready(sel_rev ? 1'b1 : out_ready),
      .out_msg(f_out_msg), .out_data(f_out_data), .out_dst(f_out_dst)
   );

   ring_rot_buffer #(.N_INST(N), .DATA_W(DW), .DIR(ROT_BACKWARD)) u_dut_rev (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid && sel_rev), .in_ready(r_in_ready),
      .in_msg(in_msg), .in_data(in_data),
      .out_valid(r_out_valid), .out_ready(sel_rev ? out_ready : 1'b1),
      .out_msg(r_out_msg), .out_data(r_out_data), .out_dst(r_out_dst)
   );

   assign rd_in_ready  = sel_rev ? r_in_ready  : f_in_ready;
   assign rd_out_valid = sel_rev ? r_out_valid : f_out_valid;
   assign rd_out_msg   = sel_rev ? r_out_msg   : f_out_msg;
   assign rd_out_data  = sel_rev ? r_out_data  : f_out_data;
   assign rd_out_dst   = sel_rev ? r_out_dst   : f_out_dst;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n    = 1'b0;
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run_stream(input bit rev, input bit stall, output int steps);
      int si = 0;
      int oi = 0;
      steps  = 0;
      sel_rev = rev;
      while (oi < LEN && steps < 500) begin
         @(negedge clk);
         in_valid  = (si < LEN);
         in_msg    = VEC[(si < LEN) ? si : 0][8];
         in_data   = VEC[(si < LEN) ? si : 0][7:0];
         out_ready = stall ? ((steps % 3) != 2) : 1'b1;
         #1;
         if (rd_out_valid && !out_ready)
            chk(!rd_in_ready, "R6", "in_ready during output stall", int'(rd_in_ready), 0);
         if (rev && in_valid && !rd_out_valid)
            chk(rd_in_ready, "R5", "fill step accepted", int'(rd_in_ready), 1);
         if (rev && rd_out_valid && rd_in_ready)
            chk(oi % N == 0, "R5", "input taken only with slot 0", oi % N, 0);
         if (rd_out_valid && out_ready) begin
            int p   = oi % N;
            int src = rev ? (p + N - 1) % N : (p + 1) % N;
            logic [8:0] e = VEC[(oi / N) * N + src];
            logic [7:0] ed = e[8] ? e[7:0] : 8'h00;
            chk(rd_out_msg == e[8], e[8] ? (rev ? "R2" : "R1") : "R4",
                "message flag", int'(rd_out_msg), int'(e[8]));
            chk(rd_out_data == ed, e[8] ? (rev ? "R2" : "R1") : "R4",
                "payload", int'(rd_out_data), int'(ed));
            chk(int'(rd_out_dst) == p, "R3", "destination slot", int'(rd_out_dst), p);
            oi++;
         end
         if (in_valid && rd_in_ready) si++;
         steps++;
      end
      chk(steps < 500, "R6", "stream completes", steps, 0);
      @(negedge clk);
      in_valid  = 1'b0;
      out_ready = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int steps;
      do_reset();
      #1;
      // R8: idle outputs after reset
      chk(!f_out_valid, "R8", "fwd out_valid after reset", int'(f_out_valid), 0);
      chk(f_in_ready,   "R8", "fwd in_ready after reset",  int'(f_in_ready), 1);
      chk(!r_out_valid, "R8", "rev out_valid after reset", int'(r_out_valid), 0);
      chk(r_in_ready,   "R8", "rev in_ready after reset",  int'(r_in_ready), 1);

      // R7 directed: first step of a group produces no output
      sel_rev  = 1'b0;
      @(negedge clk);
      in_valid = 1'b1; in_msg = VEC[0][8]; in_data = VEC[0][7:0];
      #1;
      chk(!f_out_valid, "R7", "no output on first step", int'(f_out_valid), 0);
      chk(f_in_ready,   "R7", "first step accepted", int'(f_in_ready), 1);
      @(negedge clk);
      in_msg = VEC[1][8]; in_data = VEC[1][7:0];
      #1;
      chk(f_out_valid && f_out_data == VEC[1][7:0], "R1", "second input passes to slot 0",
          int'(f_out_data), int'(VEC[1][7:0]));
      chk(f_out_dst == '0, "R3", "slot 0 tag", int'(f_out_dst), 0);
      do_reset();

      run_stream(1'b0, 1'b0, steps);
      chk(steps == LEN + 1, "R7", "forward step count", steps, LEN + 1);
      run_stream(1'b1, 1'b0, steps);
      chk(steps == GRPS * (2 * N - 1), "R5", "backward step count", steps, GRPS * (2 * N - 1));
      run_stream(1'b0, 1'b1, steps);
      run_stream(1'b1, 1'b1, steps);

      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule